// File: doc/BRIEF.md
# Power-Rail Fault Supervisor

This block is the digital response engine of a multi-rail power manager. Comparator outputs arrive already synchronized as level flags in three groups. Major faults are thermal shutdown, boost undervoltage, inverting buck-boost undervoltage and input undervoltage lockout. These switch the rails off one group at a time, following a programmable order, and park the controller in standby. A VCOM fault cuts every rail in the same cycle. Minor undervoltage faults on the VNEG, VPOS, VEE and VDDH outputs only drop power-good and raise the interrupt. The rails stay up, and power-good returns by itself once the flag clears.

Every fault sets a sticky status bit. The active-low interrupt is the OR of all status bits gated by a per-bit enable mask. Power-up can come from a rising edge on a pin or from a single-cycle request on the register bus. It is refused while any status bit is set. Status bits are cleared by a read strobe for each register, or by any change in level of the wakeup pin.

The controller has three states. ST_STBY has all rails off. ST_ON has all rails on. ST_DRAIN is the ordered shutdown in progress. There are four transitions:
- ST_STBY to ST_ON is taken on a power-up request when status is clear and no major fault is present.
- ST_ON to ST_DRAIN is taken on a major fault.
- ST_ON to ST_STBY is taken on a VCOM fault.
- ST_DRAIN to ST_STBY is taken when the last slot has finished, or at once on a VCOM fault.

Top module: `rail_fault_sup`

## Requirements
- R1: After reset, all rails are off, pgood is low, int_n is high and both status bytes are zero.
- R2: In standby with status clear, a rising edge on pwrup_pin turns every rail on at the next clock edge and raises pgood. A pin that is held high does not restart the rails.
- R3: A one-cycle bus_pwrup pulse restarts the rails under the same conditions as the pin edge.
- R4: A fault flag sets its status bit at the next edge and drops pgood at that edge. In stat_maj, bit 0 is thermal, bit 1 is boost UV, bit 2 is inverting UV, bit 3 is input UVLO and bit 4 is VCOM. In stat_min, bit 0 is VNEG, bit 1 is VPOS, bit 2 is VEE and bit 3 is VDDH.
- R5: A major fault (stat_maj bits 0 to 3) starts an ordered shutdown. Rail i takes slot s from dn_slot[2i+1:2i] and turns off s*(dn_gap+1) edges after the fault edge. Standby is reached 4*(dn_gap+1) edges after the fault edge. No rail turns back on during the shutdown.
- R6: A VCOM fault (flag bit 4) turns every rail off at the next edge, whatever the slot settings.
- R7: A minor fault leaves all rails on and the controller in ST_ON. pgood returns high one edge after the flag clears.
- R8: While any status bit is set, neither a pin edge nor a bus request can turn a rail on.
- R9: rd_maj and rd_min each clear only their own status byte. After a read, a bit whose fault flag is still present stays set.
- R10: A change of level on wake_pin clears both status bytes, except for faults still present.
- R11: int_n is low exactly when some status bit is set and its enable bit is 1. The enable mask never stops a status bit from being set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flt_maj | input | 5 | Major fault flags; bit 4 is VCOM |
| flt_min | input | 4 | Minor undervoltage flags |
| pwrup_pin | input | 1 | Power-up pin, acts on its rising edge |
| wake_pin | input | 1 | Wakeup pin; any level change clears status |
| bus_pwrup | input | 1 | Power-up request strobe from the register bus |
| rd_maj | input | 1 | Read strobe for the major status byte |
| rd_min | input | 1 | Read strobe for the minor status byte |
| en_maj | input | 5 | Interrupt enable for stat_maj |
| en_min | input | 4 | Interrupt enable for stat_min |
| dn_slot | input | 8 | Shutdown slot, 2 bits per rail |
| dn_gap | input | 8 | Clock ticks per slot, minus one |
| rail_en | output | 4 | Rail enables |
| pgood | output | 1 | Power-good |
| int_n | output | 1 | Active-low interrupt |
| stat_maj | output | 5 | Major status bits |
| stat_min | output | 4 | Minor status bits |

## Verification
The ordered shutdown is driven from four slot and gap patterns: a rising order, the reversed order, all rails in one slot, and a mixed order with a shared slot. Each pattern is triggered by a different major fault. This separates a design that indexes slots by rail from one that ignores the slot, mixes up the step count, or latches the wrong bit. Directed cases follow. A minor fault is held over several cycles to show that the rails stay up and pgood comes back. A VCOM pulse is applied with slot settings that would otherwise stagger the shutdown. Restart attempts are made with only one byte read, and with the pin held high, to tell the per-register clear from the edge rule. A read is issued while a fault is still present, and the wakeup toggle is exercised last.

// File: rtl/fps_pkg.sv
package fps_pkg;
    typedef enum logic [1:0] {
        ST_STBY  = 2'd0,
        ST_ON    = 2'd1,
        ST_DRAIN = 2'd2
    } sup_state_e;
endpackage

// File: rtl/fps_stat.sv
module fps_stat #(
    parameter int N_MAJ = 5,
    parameter int N_MIN = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_MAJ-1:0] flt_maj,
    input  logic [N_MIN-1:0] flt_min,
    input  logic             rd_maj,
    input  logic             rd_min,
    input  logic             wake_tgl,
    input  logic [N_MAJ-1:0] en_maj,
    input  logic [N_MIN-1:0] en_min,
    output logic [N_MAJ-1:0] stat_maj,
    output logic [N_MIN-1:0] stat_min,
    output logic             irq_n,
    output logic             all_clr
);
    // a clear reloads the live flags, so a fault still present stays set
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_maj <= '0;
            stat_min <= '0;
        end else begin
            stat_maj <= (rd_maj || wake_tgl) ? flt_maj : (stat_maj | flt_maj);
            stat_min <= (rd_min || wake_tgl) ? flt_min : (stat_min | flt_min);
        end
    end

    assign irq_n   = ~(|(stat_maj & en_maj) || |(stat_min & en_min));
    assign all_clr = ~(|stat_maj) && ~(|stat_min);
endmodule

// File: rtl/fps_dnseq.sv
module fps_dnseq #(
    parameter int NRAIL = 4,
    parameter int GAP_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic                    run,
    input  logic [NRAIL*$clog2(NRAIL)-1:0] slots,
    input  logic [GAP_W-1:0]        gap,
    output logic [NRAIL-1:0]        drop,
    output logic                    done
);
    localparam int SLOT_W = $clog2(NRAIL);

    logic [SLOT_W-1:0] step_q;
    logic [GAP_W-1:0]  cnt_q;
    logic              last_tick;
    logic [SLOT_W:0]   nxt_step;

    assign last_tick = (cnt_q == gap);
    assign nxt_step  = {1'b0, step_q} + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_q <= '0;
            cnt_q  <= '0;
        end else if (start) begin
            step_q <= '0;
            cnt_q  <= '0;
        end else if (run) begin
            if (last_tick) begin
                cnt_q  <= '0;
                step_q <= step_q + 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    for (genvar i = 0; i < NRAIL; i++) begin : g_drop
        logic [SLOT_W:0] slot_i;
        assign slot_i  = {1'b0, slots[i*SLOT_W +: SLOT_W]};
        assign drop[i] = start ? (slot_i == '0)
                               : (run && last_tick && (slot_i == nxt_step));
    end

    assign done = run && last_tick && (step_q == SLOT_W'(NRAIL - 1));
endmodule

// File: rtl/rail_fault_sup.sv
module rail_fault_sup #(
    parameter int NRAIL = 4,
    parameter int GAP_W = 8,
    parameter int N_MAJ = 5,
    parameter int N_MIN = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [N_MAJ-1:0]               flt_maj,
    input  logic [N_MIN-1:0]               flt_min,
    input  logic                           pwrup_pin,
    input  logic                           wake_pin,
    input  logic                           bus_pwrup,
    input  logic                           rd_maj,
    input  logic                           rd_min,
    input  logic [N_MAJ-1:0]               en_maj,
    input  logic [N_MIN-1:0]               en_min,
    input  logic [NRAIL*$clog2(NRAIL)-1:0] dn_slot,
    input  logic [GAP_W-1:0]               dn_gap,
    output logic [NRAIL-1:0]               rail_en,
    output logic                           pgood,
    output logic                           int_n,
    output logic [N_MAJ-1:0]               stat_maj,
    output logic [N_MIN-1:0]               stat_min
);
    import fps_pkg::*;

    localparam int VCOM_BIT = N_MAJ - 1;

    sup_state_e state, nxt;
    logic pwr_q, wake_q;
    logic pwr_rise, wake_tgl, vcom_hit, sev_hit, up_ok, all_clr;
    logic seq_start, seq_run, seq_done;
    logic [NRAIL-1:0] drop;

    // pin history: pwr_q starts high so a pin held high at reset does not count as an edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pwr_q  <= 1'b1;
            wake_q <= 1'b0;
        end else begin
            pwr_q  <= pwrup_pin;
            wake_q <= wake_pin;
        end
    end

    assign pwr_rise = pwrup_pin & ~pwr_q;
    assign wake_tgl = wake_pin ^ wake_q;
    assign vcom_hit = flt_maj[VCOM_BIT];
    assign sev_hit  = |flt_maj[VCOM_BIT-1:0];
    assign up_ok    = (pwr_rise || bus_pwrup) && all_clr && ~(|flt_maj);

    fps_stat #(.N_MAJ(N_MAJ), .N_MIN(N_MIN)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .flt_maj  (flt_maj),
        .flt_min  (flt_min),
        .rd_maj   (rd_maj),
        .rd_min   (rd_min),
        .wake_tgl (wake_tgl),
        .en_maj   (en_maj),
        .en_min   (en_min),
        .stat_maj (stat_maj),
        .stat_min (stat_min),
        .irq_n    (int_n),
        .all_clr  (all_clr)
    );

    fps_dnseq #(.NRAIL(NRAIL), .GAP_W(GAP_W)) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .start (seq_start),
        .run   (seq_run),
        .slots (dn_slot),
        .gap   (dn_gap),
        .drop  (drop),
        .done  (seq_done)
    );

    always_comb begin
        nxt = state;
        unique case (state)
            ST_STBY:  if (up_ok) nxt = ST_ON;
            ST_ON: begin
                if (vcom_hit)     nxt = ST_STBY;
                else if (sev_hit) nxt = ST_DRAIN;
            end
            ST_DRAIN: if (vcom_hit || seq_done) nxt = ST_STBY;
            default:  nxt = ST_STBY;
        endcase
    end

    assign seq_start = (state == ST_ON) && (nxt == ST_DRAIN);
    assign seq_run   = (state == ST_DRAIN);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_STBY;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rail_en <= '0;
            pgood   <= 1'b0;
        end else begin
            pgood <= (nxt == ST_ON) && ~(|flt_maj) && ~(|flt_min);
            if (nxt == ST_STBY)       rail_en <= '0;
            else if (state == ST_STBY) rail_en <= '1;
            else                       rail_en <= rail_en & ~drop;
        end
    end
endmodule

// File: rtl/fps_chk.sv
module fps_chk #(
    parameter int NRAIL = 4,
    parameter int N_MAJ = 5,
    parameter int N_MIN = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [N_MAJ-1:0]     flt_maj,
    input logic [N_MIN-1:0]     flt_min,
    input logic [NRAIL-1:0]     rail_en,
    input logic                 pgood,
    input logic [N_MAJ-1:0]     stat_maj,
    input logic [N_MIN-1:0]     stat_min,
    input fps_pkg::sup_state_e  state
);
    import fps_pkg::*;

    p_fault_pg_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|flt_maj || |flt_min) |=> !pgood);

    p_bit_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|flt_maj) |=> ((stat_maj & $past(flt_maj)) == $past(flt_maj)));

    p_no_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DRAIN) |=> ((rail_en & ~$past(rail_en)) == '0));

    p_vcom_cut_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_maj[N_MAJ-1] && |rail_en) |=> (rail_en == '0));

    p_minor_stay_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ON && flt_maj == '0) |=> (state == ST_ON && rail_en == '1));

    p_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rail_en == '0 && (|stat_maj || |stat_min)) |=> (rail_en == '0));
endmodule

bind rail_fault_sup fps_chk #(.NRAIL(NRAIL), .N_MAJ(N_MAJ), .N_MIN(N_MIN)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .flt_maj  (flt_maj),
    .flt_min  (flt_min),
    .rail_en  (rail_en),
    .pgood    (pgood),
    .stat_maj (stat_maj),
    .stat_min (stat_min),
    .state    (state)
);

// File: tb/test_rail_fault_sup.sv
module test_rail_fault_sup;
    localparam int CLK_P = 10;
    localparam int NV = 4;
    localparam logic [7:0] V_SLOT [NV] = '{8'hE4, 8'h1B, 8'hAA, 8'hC5};
    localparam logic [7:0] V_GAP  [NV] = '{8'd0, 8'd2, 8'd1, 8'd3};
    localparam int         V_IDX  [NV] = '{0, 1, 2, 3};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [4:0] flt_maj = '0;
    logic [3:0] flt_min = '0;
    logic pwrup_pin = 1'b0, wake_pin = 1'b0, bus_pwrup = 1'b0;
    logic rd_maj = 1'b0, rd_min = 1'b0;
    logic [4:0] en_maj = '1;
    logic [3:0] en_min = '1;
    logic [7:0] dn_slot = 8'hE4;
    logic [7:0] dn_gap = '0;
    logic [3:0] rail_en;
    logic pgood, int_n;
    logic [4:0] stat_maj;
    logic [3:0] stat_min;

    int total = 0;
    int bad = 0;

    always #(CLK_P/2) clk = ~clk;

    rail_fault_sup i_rail_fault_sup (
        .clk(clk), .rst_n(rst_n), .flt_maj(flt_maj), .flt_min(flt_min),
        .pwrup_pin(pwrup_pin), .wake_pin(wake_pin), .bus_pwrup(bus_pwrup),
        .rd_maj(rd_maj), .rd_min(rd_min), .en_maj(en_maj), .en_min(en_min),
        .dn_slot(dn_slot), .dn_gap(dn_gap), .rail_en(rail_en), .pgood(pgood),
        .int_n(int_n), .stat_maj(stat_maj), .stat_min(stat_min)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic nxt_cyc();
        @(negedge clk);
    endtask

    task automatic pulse_bus();
        bus_pwrup = 1'b1; nxt_cyc(); bus_pwrup = 1'b0;
    endtask

    task automatic restart();
        rd_maj = 1'b1; rd_min = 1'b1; nxt_cyc();
        rd_maj = 1'b0; rd_min = 1'b0;
        pwrup_pin = 1'b0; nxt_cyc();
        pwrup_pin = 1'b1; nxt_cyc();
    endtask

    initial begin
        #(CLK_P * 50000);
        total++; bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) nxt_cyc();
        rst_n = 1'b1;
        nxt_cyc();
        // R1 reset state
        chk("R1 rails", rail_en, 0);
        chk("R1 pgood", pgood, 0);
        chk("R1 int_n", int_n, 1);
        chk("R1 status", {stat_maj, stat_min}, 0);

        // R2 pin rising edge
        pwrup_pin = 1'b1; nxt_cyc();
        chk("R2 rails on", rail_en, 4'hF);
        chk("R2 pgood", pgood, 1);

        // R5 ordered shutdown table
        for (int v = 0; v < NV; v++) begin
            int g;
            logic [3:0] expv;
            logic [3:0] bad_act, bad_exp;
            logic mism;
            g = int'(V_GAP[v]);
            dn_slot = V_SLOT[v]; dn_gap = V_GAP[v];
            flt_maj = 5'(1 << V_IDX[v]); nxt_cyc();
            flt_maj = '0;
            chk("R4 major bit", stat_maj, 32'(1 << V_IDX[v]));
            chk("R4 pgood drop", pgood, 0);
            chk("R11 int_n low", int_n, 0);
            mism = 1'b0; bad_act = '0; bad_exp = '0;
            for (int t = 0; t < 4 * (g + 1); t++) begin
                for (int r = 0; r < 4; r++) begin
                    int sl;
                    sl = int'((V_SLOT[v] >> (2 * r)) & 8'h3);
                    expv[r] = (sl * (g + 1) > t);
                end
                if (rail_en !== expv && !mism) begin
                    mism = 1'b1; bad_act = rail_en; bad_exp = expv;
                end
                nxt_cyc();
            end
            total++;
            if (mism) begin
                bad++;
                $display("FAIL R5 order vec %0d: actual=%0h expected=%0h", v, bad_act, bad_exp);
            end
            chk("R5 all off", rail_en, 0);
            restart();
            chk("R9 restart after reads", rail_en, 4'hF);
        end

        // R7 minor fault
        flt_min = 4'b0010; nxt_cyc();
        chk("R7 rails stay", rail_en, 4'hF);
        chk("R7 pgood low", pgood, 0);
        chk("R4 minor bit", stat_min, 4'b0010);
        nxt_cyc();
        flt_min = '0; nxt_cyc();
        chk("R7 pgood back", pgood, 1);
        chk("R7 rails still", rail_en, 4'hF);
        chk("R9 sticky int", int_n, 0);

        // R11 mask gates only the line
        en_min = 4'b1101; #1;
        chk("R11 masked int", int_n, 1);
        chk("R11 bit kept", stat_min, 4'b0010);
        en_min = '1;

        // R9 read with fault present
        nxt_cyc();
        flt_min = 4'b0001; rd_min = 1'b1; nxt_cyc();
        rd_min = 1'b0; flt_min = '0;
        chk("R9 sticky reread", stat_min, 4'b0001);
        rd_min = 1'b1; nxt_cyc(); rd_min = 1'b0;
        chk("R9 cleared", stat_min, 0);
        chk("R9 int_n high", int_n, 1);

        // R6 VCOM cut
        dn_slot = 8'hE4; dn_gap = 8'd5;
        flt_maj = 5'h10; nxt_cyc(); flt_maj = '0;
        chk("R6 all off", rail_en, 0);
        chk("R6 vcom bit", stat_maj, 5'h10);
        repeat (3) nxt_cyc();
        chk("R6 stays off", rail_en, 0);

        // R8 blocked restart
        flt_min = 4'b1000; nxt_cyc(); flt_min = '0;
        pwrup_pin = 1'b0; nxt_cyc(); pwrup_pin = 1'b1; nxt_cyc();
        chk("R8 pin blocked", rail_en, 0);
        pulse_bus(); nxt_cyc();
        chk("R8 bus blocked", rail_en, 0);

        // R9 per-register clear
        rd_maj = 1'b1; nxt_cyc(); rd_maj = 1'b0;
        chk("R9 maj only", stat_maj, 0);
        chk("R9 min kept", stat_min, 4'b1000);
        pulse_bus(); nxt_cyc();
        chk("R8 half clear", rail_en, 0);

        // R10 wakeup toggle
        wake_pin = 1'b1; nxt_cyc();
        chk("R10 cleared", {stat_maj, stat_min}, 0);
        repeat (2) nxt_cyc();
        chk("R2 level ignored", rail_en, 0);
        bus_pwrup = 1'b1; nxt_cyc(); bus_pwrup = 1'b0;
        chk("R3 bus restart", rail_en, 4'hF);
        chk("R3 pgood", pgood, 1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule